// File: doc/BRIEF.md
# Gshare Branch Direction and Next-Fetch Predictor

This block sits in an instruction fetch stage and decides, for each fetch address, where fetch goes next. A small direct-mapped target cache recognises previously seen taken branches and provides their destinations. A table of 2-bit saturating counters predicts the direction. The table is addressed by the global branch outcome history XOR-ed with the word-address bits of the fetch PC, so the same branch reached along different recent paths uses different counters. The next fetch address is the cached target when the address is a known branch and its counter leans taken. In every other case it is the sequential address.

The history is shifted speculatively with the predicted direction whenever a known branch is fetched. Each prediction hands out the table index it used and the history value before the shift (a checkpoint). The back end returns both on its resolve port. The counter is trained at that carried index. On a misprediction the history is rebuilt from the checkpoint with the real outcome appended.

Top module: `gshare_predictor`

## Requirements
- R1: After a synchronous active-low reset the history reads all zeros, every counter holds 01 (weakly not taken, so `pred_taken` is 0), and no fetch address hits the target cache.
- R2: `pred_index` equals the history XOR `pred_pc[HIST_W+1:2]` (4-byte instructions; the two lowest PC bits are not used).
- R3: `pred_hit` is 1 only when the target cache entry at `pred_pc[BTB_IDX_W+1:2]` is valid and its tag equals `pred_pc[PC_W-1:BTB_IDX_W+2]`.
- R4: `pred_next_pc` is the cached target when `pred_hit` and `pred_taken` are both 1. Otherwise it is `pred_pc + 4`.
- R5: `pred_taken` is bit 1 of the counter at `pred_index`. Each cycle with `res_valid`, the counter at `res_index` moves up by one on `res_taken` and down by one otherwise. It stays at 11 and at 00 when already there.
- R6: On a cycle with `pred_valid` and `pred_hit`, and no misprediction repair, the history shifts left by one and takes `pred_taken` into bit 0. Otherwise, without a repair, it holds.
- R7: `pred_ckpt` shows the history before the current prediction. On `res_valid` with `res_mispredict`, the history becomes `{res_ckpt[HIST_W-2:0], res_taken}`. This takes priority over a speculative shift in the same cycle.
- R8: A resolved taken branch writes its tag and `res_target` into the cache entry selected by `res_pc`, replacing any entry already there. A resolved not-taken branch leaves the cache unchanged.
- R9: When a prediction and a resolve occur in the same cycle, the prediction uses the counter, cache and history as they stood before the update. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | A fetch address is presented this cycle |
| pred_pc | input | PC_W | Fetch address |
| pred_hit | output | 1 | Fetch address is a known branch |
| pred_taken | output | 1 | Counter direction at the prediction index |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| pred_index | output | HIST_W | Table index to carry with the branch |
| pred_ckpt | output | HIST_W | History before this prediction |
| res_valid | input | 1 | A branch outcome is reported |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | PC_W | Actual target address |
| res_index | input | HIST_W | Index returned from the prediction |
| res_ckpt | input | HIST_W | Checkpoint returned from the prediction |
| res_mispredict | input | 1 | Direction or target was mispredicted |

## Verification
The assertions assume that every input is at a known value on each clock edge after reset. They make no assumption about consistency between the resolve fields and earlier predictions: the history and counter rules must hold even for an index or checkpoint that was never issued. The stimulus mixes directed sequences with random resolve fields over a small address window. This window makes cache hits, tag conflicts and counter saturation frequent. It also lets repairs and speculative shifts collide in the same cycle.

// File: rtl/gshare_pkg.sv
// Shared counter type and update rule for the gshare predictor.
// Assumes 2-bit counters; bit 1 is the predicted direction.
package gshare_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b01;

    // Saturating step of a direction counter toward the observed outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != 2'b11) nxt = cur + 2'b01;
        else if (!taken && cur != 2'b00) nxt = cur - 2'b01;
        return nxt;
    endfunction
endpackage

// File: rtl/gs_history.sv
// Global outcome history register with speculative shift and checkpoint repair.
// Assumes the repair request wins over a speculative shift in the same cycle.
module gs_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_ckpt,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    // History update: reset, repair from checkpoint, or speculative shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       hist_q <= '0;
        else if (fix_en)  hist_q <= {fix_ckpt[HIST_W-2:0], fix_bit};
        else if (spec_en) hist_q <= {hist_q[HIST_W-2:0], spec_bit};
    end

    assign hist = hist_q;
endmodule

// File: rtl/gs_pht.sv
// Pattern table of 2-bit saturating counters, one per index value.
// Asynchronous read port; one write port trained at a carried index.
module gs_pht
    import gshare_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output ctr_t              rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken
);
    localparam int ENTRIES = 1 << HIST_W;

    ctr_t tbl [ENTRIES];

    // Counter training and reset to weakly not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_RESET;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    // Read of the counter at the prediction index.
    always_comb rd_ctr = tbl[rd_idx];
endmodule

// File: rtl/gs_btb.sv
// Direct-mapped branch target cache: valid bit, tag and target per entry.
// Lookup is combinational; a write allocates or overwrites an entry.
module gs_btb #(
    parameter int PC_W      = 32,
    parameter int IDX_W     = 4,
    parameter int OFF_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W - OFF_W;

    logic              vld_q [ENTRIES];
    logic [TAG_W-1:0]  tag_q [ENTRIES];
    logic [PC_W-1:0]   tgt_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    // Split addresses into set index and tag.
    always_comb begin
        lk_idx = lk_pc[OFF_W +: IDX_W];
        lk_tag = lk_pc[PC_W-1 -: TAG_W];
        wr_idx = wr_pc[OFF_W +: IDX_W];
        wr_tag = wr_pc[PC_W-1 -: TAG_W];
    end

    // Valid bits: cleared at reset, set on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target storage, no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    // Hit detection and target read.
    always_comb begin
        lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_target = tgt_q[lk_idx];
    end
endmodule

// File: rtl/gshare_predictor.sv
// Top of the gshare predictor: forms the table index, fuses direction and
// target lookup into a next fetch address, and applies resolve updates.
// Assumes fixed-size instructions of INST_BYTES bytes (power of two).
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int HIST_W     = 8,
    parameter int BTB_IDX_W  = 4,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [PC_W-1:0]   pred_next_pc,
    output logic [HIST_W-1:0] pred_index,
    output logic [HIST_W-1:0] pred_ckpt,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [PC_W-1:0]   res_target,
    input  logic [HIST_W-1:0] res_index,
    input  logic [HIST_W-1:0] res_ckpt,
    input  logic              res_mispredict
);
    localparam int OFF_W = $clog2(INST_BYTES);

    logic [HIST_W-1:0] hist;
    ctr_t              ctr;
    logic              btb_hit;
    logic [PC_W-1:0]   btb_tgt;

    gs_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (pred_valid && btb_hit),
        .spec_bit (ctr[1]),
        .fix_en   (res_valid && res_mispredict),
        .fix_ckpt (res_ckpt),
        .fix_bit  (res_taken),
        .hist     (hist)
    );

    gs_pht #(.HIST_W(HIST_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_index),
        .rd_ctr   (ctr),
        .wr_en    (res_valid),
        .wr_idx   (res_index),
        .wr_taken (res_taken)
    );

    gs_btb #(.PC_W(PC_W), .IDX_W(BTB_IDX_W), .OFF_W(OFF_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (pred_pc),
        .lk_hit    (btb_hit),
        .lk_target (btb_tgt),
        .wr_en     (res_valid && res_taken),
        .wr_pc     (res_pc),
        .wr_target (res_target)
    );

    // Hashed index, checkpoint and fused next fetch address.
    always_comb begin
        pred_index   = hist ^ pred_pc[OFF_W +: HIST_W];
        pred_ckpt    = hist;
        pred_hit     = btb_hit;
        pred_taken   = ctr[1];
        pred_next_pc = (btb_hit && ctr[1]) ? btb_tgt
                                           : pred_pc + PC_W'(INST_BYTES);
    end
endmodule

// File: rtl/gshare_chk.sv
// Checker for gshare_predictor: history repair, speculative shift,
// reset state and sequential fall-through, observed at the ports.
module gshare_chk #(
    parameter int PC_W       = 32,
    parameter int HIST_W     = 8,
    parameter int INST_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_valid,
    input logic [PC_W-1:0]   pred_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [PC_W-1:0]   pred_next_pc,
    input logic [HIST_W-1:0] pred_ckpt,
    input logic              res_valid,
    input logic              res_taken,
    input logic [HIST_W-1:0] res_ckpt,
    input logic              res_mispredict
);
    // R1
    reset_hist_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pred_ckpt == '0 && !pred_hit && !pred_taken));

    // R7
    repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |=>
            pred_ckpt == {$past(res_ckpt[HIST_W-2:0]), $past(res_taken)});

    // R6
    spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_hit && !(res_valid && res_mispredict)) |=>
            pred_ckpt == {$past(pred_ckpt[HIST_W-2:0]), $past(pred_taken)});

    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(pred_valid && pred_hit) && !(res_valid && res_mispredict)) |=>
            $stable(pred_ckpt));

    // R4
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_hit || !pred_taken) |-> pred_next_pc == pred_pc + PC_W'(INST_BYTES));
endmodule

bind gshare_predictor gshare_chk #(
    .PC_W(PC_W), .HIST_W(HIST_W), .INST_BYTES(INST_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .pred_ckpt(pred_ckpt), .res_valid(res_valid), .res_taken(res_taken),
    .res_ckpt(res_ckpt), .res_mispredict(res_mispredict)
);

// File: tb/tb_gshare_predictor.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module tb_gshare_predictor;
    localparam int PC_W = 32;
    localparam int HW   = 8;
    localparam int BIW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pred_valid = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_hit, pred_taken;
    logic [PC_W-1:0] pred_next_pc;
    logic [HW-1:0]   pred_index, pred_ckpt;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0;
    logic [PC_W-1:0] res_target = '0;
    logic [HW-1:0]   res_index = '0;
    logic [HW-1:0]   res_ckpt = '0;
    logic            res_mispredict = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference state
    int          m_ctr [256];
    bit          m_vld [16];
    int unsigned m_tag [16];
    int unsigned m_tgt [16];
    int unsigned m_hist;

    always #10 clk = ~clk;

    gshare_predictor #(.PC_W(PC_W), .HIST_W(HW), .BTB_IDX_W(BIW), .INST_BYTES(4)) dut (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .pred_index(pred_index), .pred_ckpt(pred_ckpt), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
        .res_index(res_index), .res_ckpt(res_ckpt), .res_mispredict(res_mispredict)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_ctr[i] = 1;
        for (int i = 0; i < 16; i++) m_vld[i] = 0;
        m_hist = 0;
    endtask

    // One cycle: drive, compare with the model, then advance the model.
    task automatic step(input bit pv, input int unsigned ppc, input bit rv,
                        input int unsigned rpc, input bit rt, input int unsigned rtg,
                        input int unsigned ridx, input int unsigned rck, input bit rm);
        int unsigned e_idx, bi, e_next;
        bit e_hit, e_tk;
        @(negedge clk);
        pred_valid = pv; pred_pc = ppc; res_valid = rv; res_pc = rpc;
        res_taken = rt; res_target = rtg; res_index = HW'(ridx);
        res_ckpt = HW'(rck); res_mispredict = rm;
        #1;
        e_idx  = (m_hist ^ (ppc >> 2)) & 255;
        bi     = (ppc >> 2) & 15;
        e_hit  = m_vld[bi] && (m_tag[bi] == (ppc >> 6));
        e_tk   = m_ctr[e_idx] >= 2;
        e_next = (e_hit && e_tk) ? m_tgt[bi] : ppc + 4;
        chk(pred_index == HW'(e_idx), "R2 index", pred_index, e_idx);
        chk(pred_hit == e_hit, "R3 hit", pred_hit, e_hit);
        chk(pred_taken == e_tk, "R5 counter dir", pred_taken, e_tk);
        chk(pred_next_pc == e_next, "R4 next pc", pred_next_pc, e_next);
        chk(pred_ckpt == HW'(m_hist), "R6 R7 history", pred_ckpt, m_hist);
        @(posedge clk);
        if (rv) begin
            if (rt && m_ctr[ridx & 255] < 3) m_ctr[ridx & 255]++;
            else if (!rt && m_ctr[ridx & 255] > 0) m_ctr[ridx & 255]--;
            if (rt) begin
                m_vld[(rpc >> 2) & 15] = 1;
                m_tag[(rpc >> 2) & 15] = rpc >> 6;
                m_tgt[(rpc >> 2) & 15] = rtg;
            end
        end
        if (rv && rm) m_hist = ((rck << 1) | rt) & 255;
        else if (pv && e_hit) m_hist = ((m_hist << 1) | e_tk) & 255;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        pred_pc = 32'h1000; #1;
        chk(pred_ckpt == 0, "R1 history zero", pred_ckpt, 0);
        chk(pred_hit == 0, "R1 cache empty", pred_hit, 0);
        chk(pred_taken == 0, "R1 counter 01", pred_taken, 0);
        // R8: taken resolve allocates; not-taken does not
        step(0, 32'h1000, 1, 32'h1000, 1, 32'h2000, 0, 0, 0);
        step(0, 32'h1010, 1, 32'h1010, 0, 32'h3000, 4, 0, 0);
        step(1, 32'h1000, 0, 0, 0, 0, 0, 0, 0);
        step(0, 32'h1010, 0, 0, 0, 0, 0, 0, 0);
        chk(pred_hit == 0, "R8 not-taken no alloc", pred_hit, 0);
        // R5: saturate up then down at one index
        for (int k = 0; k < 5; k++) step(0, 32'h1000, 1, 32'h1000, 1, 32'h2000, 8'h05, 0, 0);
        for (int k = 0; k < 5; k++) step(0, 32'h1014, 1, 32'h1000, 0, 32'h2000, 8'h05, 0, 0);
        // R9: predict and resolve the same branch in one cycle
        step(1, 32'h1000, 1, 32'h1000, 1, 32'h2400, 32'h1000 >> 2, 0, 0);
        step(1, 32'h1000, 1, 32'h1040, 1, 32'h2800, 0, 8'h3c, 1);
        // R3: tag conflict on the same set
        step(1, 32'h1000, 0, 0, 0, 0, 0, 0, 0);
        // R7: repair colliding with speculative shift
        step(1, 32'h1040, 1, 32'h1040, 0, 0, 1, 8'hff, 1);
        // mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            int unsigned a, b;
            a = 32'h1000 + ($urandom % 24) * 4;
            b = 32'h1000 + ($urandom % 24) * 4;
            step($urandom % 4 != 0, a, $urandom % 2, b, $urandom % 3 != 0,
                 32'h8000 + ($urandom % 256) * 4, $urandom % 256, $urandom % 256,
                 $urandom % 5 == 0);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule